// File: doc/BRIEF.md
# Page Table Address Translator

This block maps virtual addresses to physical addresses through a single-level page table kept in flip-flops inside the block. The low `OFF_W` bits of a virtual address are the byte offset within a page. The remaining upper bits are the page number, and the page number indexes the table. Each entry holds a physical frame number and four flags: resident, no-execute, used and dirty. A request carries an address, a write qualifier and an instruction-fetch qualifier. One cycle later the block returns either a physical address or exactly one fault indication.

The block checks each request in a fixed order:
- A page number beyond the table raises a segmentation fault.
- Otherwise, a non-resident entry raises a page fault.
- Otherwise, an instruction fetch from a no-execute page raises an execute violation.

A successful access marks its entry as used. A successful write also marks the entry dirty. Software installs entries and clears the used and dirty marks through a separate port, and it can read any entry back combinationally. Bringing pages in from backing storage and choosing which pages to evict are left to software.

Top module: `pt_xlate`

## Requirements
- R1: One cycle after an accepted request (`req_valid`=1), `rsp_valid`=1 and `rsp_paddr` = {frame of entry[page], low `OFF_W` address bits unchanged}. With the defaults, virtual address 0x3C90 and entry 3 holding frame 0x1662 give 0x1662C90. `rsp_valid`=0 in the cycle after a cycle with no request.
- R2: A page number (address bits `VA_W-1:OFF_W`) of `N_ENT` or more gives `rsp_seg_fault`=1.
- R3: An in-range page whose resident flag is 0 gives `rsp_page_fault`=1, and no translation is returned.
- R4: A fetch (`req_fetch`=1) from a resident page with no-execute=1 gives `rsp_nx_fault`=1. Reads and writes that are not fetches translate normally on such a page.
- R5: At most one fault output is 1 per response, in the priority segmentation, then page, then execute. When any fault is 1, `rsp_paddr` is 0.
- R6: A non-faulting access sets the used flag of its entry. A non-faulting access with `req_write`=1 also sets the dirty flag. The new flags are visible on the read port after the same clock edge that delivers the response.
- R7: A faulting access changes no used or dirty flag.
- R8: `sw_clr_en` with `sw_clr_used`/`sw_clr_dirty` clears the selected flags of entry `sw_clr_idx`, and the two flags are cleared independently. If a hardware set of the same flag on the same entry happens in the same cycle, the flag ends up set.
- R9: `sw_wr_en` loads frame, resident and no-execute into entry `sw_wr_idx` and clears its used and dirty flags, with a same-cycle hardware set still winning. An access in that same cycle is translated with the previous entry contents.
- R10: After reset every entry reads back as zero (non-resident), all response outputs are 0, and the read port returns zeros for an index at or beyond `N_ENT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | VA_W | Virtual address |
| req_write | input | 1 | Request is a data write |
| req_fetch | input | 1 | Request is an instruction fetch |
| rsp_valid | output | 1 | Response present (one cycle after the request) |
| rsp_paddr | output | PFN_W+OFF_W | Physical address, 0 on any fault |
| rsp_seg_fault | output | 1 | Page number outside the table |
| rsp_page_fault | output | 1 | Entry not resident |
| rsp_nx_fault | output | 1 | Fetch from a no-execute page |
| sw_wr_en | input | 1 | Install an entry |
| sw_wr_idx | input | VA_W-OFF_W | Entry to install |
| sw_wr_pfn | input | PFN_W | Frame number to install |
| sw_wr_resident | input | 1 | Resident flag to install |
| sw_wr_noexec | input | 1 | No-execute flag to install |
| sw_clr_en | input | 1 | Clear flags of one entry |
| sw_clr_idx | input | VA_W-OFF_W | Entry whose flags are cleared |
| sw_clr_used | input | 1 | Clear the used flag |
| sw_clr_dirty | input | 1 | Clear the dirty flag |
| sw_rd_idx | input | VA_W-OFF_W | Entry to read back |
| sw_rd_pfn | output | PFN_W | Frame number of that entry |
| sw_rd_resident | output | 1 | Resident flag of that entry |
| sw_rd_noexec | output | 1 | No-execute flag of that entry |
| sw_rd_used | output | 1 | Used flag of that entry |
| sw_rd_dirty | output | 1 | Dirty flag of that entry |

## Verification
A hardware flag set from a successful access and a software clear or entry install aimed at the same entry can land on the same clock edge. The bench provokes this by driving a write access to an entry together with a clear of both its flags, a read access together with a clear of only its dirty flag, and a read access together with a reinstall of the entry it hits. It judges the outcome through the read port: a set flag wins over a clear, and the response still carries the frame the entry held before the install.

// File: rtl/pt_xlate.sv
module pt_xlate #(
  parameter int VA_W  = 16,
  parameter int OFF_W = 12,
  parameter int PFN_W = 16,
  parameter int N_ENT = 10,
  localparam int VPN_W = VA_W - OFF_W,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1,
  localparam int PA_W  = PFN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_write,
  input  logic             req_fetch,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_seg_fault,
  output logic             rsp_page_fault,
  output logic             rsp_nx_fault,
  input  logic             sw_wr_en,
  input  logic [VPN_W-1:0] sw_wr_idx,
  input  logic [PFN_W-1:0] sw_wr_pfn,
  input  logic             sw_wr_resident,
  input  logic             sw_wr_noexec,
  input  logic             sw_clr_en,
  input  logic [VPN_W-1:0] sw_clr_idx,
  input  logic             sw_clr_used,
  input  logic             sw_clr_dirty,
  input  logic [VPN_W-1:0] sw_rd_idx,
  output logic [PFN_W-1:0] sw_rd_pfn,
  output logic             sw_rd_resident,
  output logic             sw_rd_noexec,
  output logic             sw_rd_used,
  output logic             sw_rd_dirty
);

  logic [PFN_W-1:0] pfn_q [N_ENT];
  logic [N_ENT-1:0] res_q, nx_q, used_q, dirty_q;
  logic [N_ENT-1:0] used_d, dirty_d;

  logic [VPN_W-1:0] vpn;
  logic [IDX_W-1:0] idx, rd_idx;
  logic             in_rng, e_res, e_nx, f_seg, f_pf, f_nx, ok;

  assign vpn    = req_vaddr[VA_W-1:OFF_W];
  assign idx    = IDX_W'(vpn);
  assign in_rng = 32'(vpn) < N_ENT;
  assign e_res  = in_rng & res_q[idx];
  assign e_nx   = in_rng & nx_q[idx];

  assign f_seg = req_valid & ~in_rng;
  assign f_pf  = req_valid & in_rng & ~e_res;
  assign f_nx  = req_valid & e_res & req_fetch & e_nx;
  assign ok    = req_valid & e_res & ~(req_fetch & e_nx);

  for (genvar i = 0; i < N_ENT; i++) begin : g_flag
    logic wr_i, clr_i, hit_i;
    assign wr_i  = sw_wr_en  && (32'(sw_wr_idx) == i);
    assign clr_i = sw_clr_en && (32'(sw_clr_idx) == i);
    assign hit_i = ok && (32'(vpn) == i);
    assign used_d[i]  = hit_i |
                        (used_q[i] & ~wr_i & ~(clr_i & sw_clr_used));
    assign dirty_d[i] = (hit_i & req_write) |
                        (dirty_q[i] & ~wr_i & ~(clr_i & sw_clr_dirty));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used_q  <= '0;
      dirty_q <= '0;
      res_q   <= '0;
      nx_q    <= '0;
      for (int i = 0; i < N_ENT; i++) pfn_q[i] <= '0;
    end else begin
      used_q  <= used_d;
      dirty_q <= dirty_d;
      for (int i = 0; i < N_ENT; i++) begin
        if (sw_wr_en && (32'(sw_wr_idx) == i)) begin
          pfn_q[i] <= sw_wr_pfn;
          res_q[i] <= sw_wr_resident;
          nx_q[i]  <= sw_wr_noexec;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_paddr      <= '0;
      rsp_seg_fault  <= 1'b0;
      rsp_page_fault <= 1'b0;
      rsp_nx_fault   <= 1'b0;
    end else begin
      rsp_valid      <= req_valid;
      rsp_paddr      <= ok ? {pfn_q[idx], req_vaddr[OFF_W-1:0]} : '0;
      rsp_seg_fault  <= f_seg;
      rsp_page_fault <= f_pf;
      rsp_nx_fault   <= f_nx;
    end
  end

  logic rd_ok;
  assign rd_ok          = 32'(sw_rd_idx) < N_ENT;
  assign rd_idx         = IDX_W'(sw_rd_idx);
  assign sw_rd_pfn      = rd_ok ? pfn_q[rd_idx] : '0;
  assign sw_rd_resident = rd_ok & res_q[rd_idx];
  assign sw_rd_noexec   = rd_ok & nx_q[rd_idx];
  assign sw_rd_used     = rd_ok & used_q[rd_idx];
  assign sw_rd_dirty    = rd_ok & dirty_q[rd_idx];

endmodule

// File: rtl/pt_xlate_chk.sv
module pt_xlate_chk #(
  parameter int VA_W  = 16,
  parameter int OFF_W = 12,
  parameter int PFN_W = 16,
  parameter int N_ENT = 10,
  localparam int PA_W = PFN_W + OFF_W
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [VA_W-1:0] req_vaddr,
  input logic            req_fetch,
  input logic            rsp_valid,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            rsp_seg_fault,
  input logic            rsp_page_fault,
  input logic            rsp_nx_fault
);

  logic any_fault;
  assign any_fault = rsp_seg_fault | rsp_page_fault | rsp_nx_fault;

  p_rsp_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_no_rsp_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  p_offset_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (any_fault ||
      rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])));

  p_seg_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (32'(req_vaddr[VA_W-1:OFF_W]) >= N_ENT)) |=> rsp_seg_fault);

  p_nx_only_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_fetch) |=> !rsp_nx_fault);

  p_single_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_seg_fault, rsp_page_fault, rsp_nx_fault}));

  p_fault_zero_pa_r5: assert property (@(posedge clk) disable iff (!rst_n)
    any_fault |-> (rsp_paddr == '0));

  p_fault_needs_rsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    any_fault |-> rsp_valid);

endmodule

bind pt_xlate pt_xlate_chk #(
  .VA_W(VA_W), .OFF_W(OFF_W), .PFN_W(PFN_W), .N_ENT(N_ENT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
  .req_fetch(req_fetch), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
  .rsp_seg_fault(rsp_seg_fault), .rsp_page_fault(rsp_page_fault),
  .rsp_nx_fault(rsp_nx_fault)
);

// File: tb/pt_xlate_tb_top.sv
module pt_xlate_tb_top;
  localparam int VA_W = 16, OFF_W = 12, PFN_W = 16, N_ENT = 10;
  localparam int VPN_W = VA_W - OFF_W, PA_W = PFN_W + OFF_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_fetch = 0;
  logic [VA_W-1:0] req_vaddr = '0;
  logic rsp_valid, rsp_seg_fault, rsp_page_fault, rsp_nx_fault;
  logic [PA_W-1:0] rsp_paddr;
  logic sw_wr_en = 0, sw_wr_resident = 0, sw_wr_noexec = 0;
  logic [VPN_W-1:0] sw_wr_idx = '0, sw_clr_idx = '0, sw_rd_idx = '0;
  logic [PFN_W-1:0] sw_wr_pfn = '0;
  logic sw_clr_en = 0, sw_clr_used = 0, sw_clr_dirty = 0;
  logic [PFN_W-1:0] sw_rd_pfn;
  logic sw_rd_resident, sw_rd_noexec, sw_rd_used, sw_rd_dirty;

  always #2 clk = ~clk;

  pt_xlate #(.VA_W(VA_W), .OFF_W(OFF_W), .PFN_W(PFN_W), .N_ENT(N_ENT)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_fetch(req_fetch), .rsp_valid(rsp_valid),
    .rsp_paddr(rsp_paddr), .rsp_seg_fault(rsp_seg_fault),
    .rsp_page_fault(rsp_page_fault), .rsp_nx_fault(rsp_nx_fault),
    .sw_wr_en(sw_wr_en), .sw_wr_idx(sw_wr_idx), .sw_wr_pfn(sw_wr_pfn),
    .sw_wr_resident(sw_wr_resident), .sw_wr_noexec(sw_wr_noexec),
    .sw_clr_en(sw_clr_en), .sw_clr_idx(sw_clr_idx), .sw_clr_used(sw_clr_used),
    .sw_clr_dirty(sw_clr_dirty), .sw_rd_idx(sw_rd_idx), .sw_rd_pfn(sw_rd_pfn),
    .sw_rd_resident(sw_rd_resident), .sw_rd_noexec(sw_rd_noexec),
    .sw_rd_used(sw_rd_used), .sw_rd_dirty(sw_rd_dirty)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [PFN_W-1:0] m_pfn [N_ENT];
  logic m_res [N_ENT], m_nx [N_ENT], m_used [N_ENT], m_dirty [N_ENT];

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_entry(int i, string tag);
    sw_rd_idx = VPN_W'(i);
    #0.5;
    check({tag, " pfn"},   64'(sw_rd_pfn),      64'(m_pfn[i]));
    check({tag, " res"},   64'(sw_rd_resident), 64'(m_res[i]));
    check({tag, " nx"},    64'(sw_rd_noexec),   64'(m_nx[i]));
    check({tag, " used"},  64'(sw_rd_used),     64'(m_used[i]));
    check({tag, " dirty"}, 64'(sw_rd_dirty),    64'(m_dirty[i]));
  endtask

  task automatic install(int i, logic [PFN_W-1:0] pfn, logic r, logic x);
    @(negedge clk);
    sw_wr_en = 1; sw_wr_idx = VPN_W'(i); sw_wr_pfn = pfn;
    sw_wr_resident = r; sw_wr_noexec = x;
    @(posedge clk); #1;
    sw_wr_en = 0;
    m_pfn[i] = pfn; m_res[i] = r; m_nx[i] = x; m_used[i] = 0; m_dirty[i] = 0;
  endtask

  task automatic access(logic [VA_W-1:0] va, logic wr, logic fe);
    int v;
    logic seg, pf, nx, ok;
    logic [PA_W-1:0] exp_pa;
    @(negedge clk);
    req_valid = 1; req_vaddr = va; req_write = wr; req_fetch = fe;
    @(posedge clk); #1;
    req_valid = 0;
    v   = int'(va[VA_W-1:OFF_W]);
    seg = (v >= N_ENT);
    pf  = !seg && !m_res[v];
    nx  = !seg && !pf && fe && m_nx[v];
    ok  = !seg && !pf && !nx;
    exp_pa = ok ? {m_pfn[v], va[OFF_W-1:0]} : '0;
    check("R1 rsp_valid", 64'(rsp_valid), 64'd1);
    check(ok ? "R1 paddr" : "R5 paddr zero", 64'(rsp_paddr), 64'(exp_pa));
    check("R2 seg", 64'(rsp_seg_fault), 64'(seg));
    check("R3 page", 64'(rsp_page_fault), 64'(pf));
    check("R4 nx", 64'(rsp_nx_fault), 64'(nx));
    if (ok) begin
      m_used[v] = 1;
      if (wr) m_dirty[v] = 1;
    end
    if (!seg) chk_entry(v, ok ? "R6 flags" : "R7 flags");
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N_ENT; i++) begin
      m_pfn[i] = '0; m_res[i] = 0; m_nx[i] = 0; m_used[i] = 0; m_dirty[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    check("R10 rsp_valid", 64'(rsp_valid), 0);
    check("R10 faults", 64'({rsp_seg_fault, rsp_page_fault, rsp_nx_fault}), 0);
    check("R10 paddr", 64'(rsp_paddr), 0);
    @(negedge clk); rst_n = 1;
    for (int i = 0; i < N_ENT; i++) chk_entry(i, "R10 reset entry");
    sw_rd_idx = VPN_W'(12); #0.5;
    check("R10 rd out of range", 64'({sw_rd_pfn, sw_rd_resident, sw_rd_used}), 0);

    for (int i = 0; i < N_ENT; i++)
      install(i, (i == 3) ? 16'h1662 : PFN_W'(16'h0400 + i * 16'h0123),
              (i % 3) != 1, ((i % 4) == 2) || (i == 7));
    for (int i = 0; i < N_ENT; i++) chk_entry(i, "R9 installed");

    access(16'h3C90, 0, 0);
    check("R1 worked example", 64'(rsp_paddr), 64'h1662C90);

    for (int v = 0; v < 16; v++)
      for (int m = 0; m < 3; m++)
        access({VPN_W'(v), OFF_W'(v * 12'h1F3 + m * 12'h0A7)}, m == 1, m == 2);

    // R8: clear collides with a write access on entry 0, set wins
    @(negedge clk);
    req_valid = 1; req_vaddr = 16'h0ABC; req_write = 1; req_fetch = 0;
    sw_clr_en = 1; sw_clr_idx = '0; sw_clr_used = 1; sw_clr_dirty = 1;
    @(posedge clk); #1;
    req_valid = 0; sw_clr_en = 0;
    check("R8 collide paddr", 64'(rsp_paddr), 64'({m_pfn[0], 12'hABC}));
    m_used[0] = 1; m_dirty[0] = 1;
    chk_entry(0, "R8 set beats clear");

    // R8: independent clears
    @(negedge clk);
    sw_clr_en = 1; sw_clr_idx = '0; sw_clr_used = 1; sw_clr_dirty = 0;
    @(posedge clk); #1; sw_clr_en = 0;
    m_used[0] = 0;
    chk_entry(0, "R8 clear used only");
    @(negedge clk);
    sw_clr_en = 1; sw_clr_used = 0; sw_clr_dirty = 1;
    @(posedge clk); #1; sw_clr_en = 0;
    m_dirty[0] = 0;
    chk_entry(0, "R8 clear dirty only");

    // R8: read access with dirty clear on a dirty entry
    access(16'h5010, 1, 0);
    @(negedge clk);
    req_valid = 1; req_vaddr = 16'h5020; req_write = 0; req_fetch = 0;
    sw_clr_en = 1; sw_clr_idx = VPN_W'(5); sw_clr_used = 0; sw_clr_dirty = 1;
    @(posedge clk); #1;
    req_valid = 0; sw_clr_en = 0;
    m_dirty[5] = 0;
    chk_entry(5, "R8 read plus dirty clear");

    // R9: reinstall collides with access; old frame used, used flag set
    @(negedge clk);
    req_valid = 1; req_vaddr = 16'h5FFF; req_write = 0; req_fetch = 0;
    sw_wr_en = 1; sw_wr_idx = VPN_W'(5); sw_wr_pfn = 16'h0ABC;
    sw_wr_resident = 1; sw_wr_noexec = 0;
    @(posedge clk); #1;
    req_valid = 0; sw_wr_en = 0;
    check("R9 old frame used", 64'(rsp_paddr), 64'({m_pfn[5], 12'hFFF}));
    m_pfn[5] = 16'h0ABC; m_used[5] = 1; m_dirty[5] = 0;
    chk_entry(5, "R9 install with access");
    access(16'h5123, 0, 0);

    // R3/R9: make page 1 resident, then translate; R4 priority on entry 7
    install(1, 16'h7777, 1, 0);
    access(16'h1456, 1, 0);
    access(16'h7001, 0, 1);

    @(negedge clk); #1;
    check("R1 idle no rsp", 64'(rsp_valid), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule